// File: doc/BRIEF.md
# LNB Supply Mode Decoder and 22 kHz Tone Source

This block sits between the control register of a satellite LNB supply controller and its analog power stage. It reads five register bits and one pin that is already synchronized to the system clock. The five bits are the master enable, the communication mode, the voltage/boost control bit, cable-drop compensation and the transmit-port select. From these it produces the settings the power stage needs:

- a 2-bit output-voltage code,
- a 2-bit boost-rail code,
- enables for the transmit and receive output ports,
- a master power enable,
- a 22 kHz square tone.

The tone comes from dividing the system clock.

The pin has one of two jobs, chosen by the mode bit. In tone mode it gates the tone, and the voltage bit picks the output level. In voltage-word mode the pin picks the output level, and the voltage bit changes meaning: it pins the boost rail to its high setting so that the output can be toggled quickly. All decoded outputs are registered, so they change one clock edge after their inputs and never glitch when the mode changes.

Code encoding, used for both the output code and the boost code: bit 1 selects the high level and bit 0 adds the 1 V cable step. Output codes 0 to 3 mean 13.25, 14.25, 19.5 and 20.5 V. Boost codes 0 to 3 mean 15.45, 16.45, 21.7 and 22.7 V.

Top module: `lnb_supply_ctrl`

## Requirements
- R1: With `enBit` low, the next edge drives `pwrEn`, `txEn` and `rxEn` low and both codes to 0. The tone is also cut to low at once, even in the middle of a half-period.
- R2: With `enBit` high and `modeSel` low, `outCode[1]` equals `vhiBit` and the pin has no effect on either code.
- R3: With `enBit` high, bit 0 of both `outCode` and `boostCode` equals `dropComp`.
- R4: With `enBit` high, `boostCode` equals `outCode` in every case except `modeSel`=1 with `vhiBit`=1.
- R5: With `enBit` and `modeSel` high and `vhiBit` low, `outCode[1]` and `boostCode[1]` both equal `selPin`.
- R6: With `enBit`, `modeSel` and `vhiBit` high, `outCode[1]` equals `selPin` and `boostCode[1]` is 1.
- R7: With `enBit` high, `txSel`=1 gives `txEn`=1 and `rxEn`=0, and `txSel`=0 gives `txEn`=0 and `rxEn`=1. `pwrEn` is 1.
- R8: When `enBit` is high, `modeSel` is low and `selPin` is high while the tone is idle, `toneOut` goes high on the next edge. It then alternates, HALF cycles high and HALF cycles low, with HALF = CLK_HZ/(2*TONE_HZ).
- R9: When the pin drops during a high half, the tone stays high until that half completes, then goes low and idles. When it drops during a low half, the tone stays low and idles. Raising the pin again from idle restarts the tone at phase zero.
- R10: With `modeSel` high, or with the pin low while the tone is idle, `toneOut` stays low.
- R11: Every output is registered and reflects its inputs one edge later. During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enBit | input | 1 | Master enable register bit |
| modeSel | input | 1 | 0 = tone mode, 1 = voltage-word mode |
| vhiBit | input | 1 | Output high select (tone mode) or boost force (word mode) |
| dropComp | input | 1 | Adds the 1 V cable-drop step |
| txSel | input | 1 | Selects the transmit output port |
| selPin | input | 1 | Synchronized control pin |
| outCode | output | 2 | Output-voltage code |
| boostCode | output | 2 | Boost-rail code |
| toneOut | output | 1 | 22 kHz tone waveform |
| txEn | output | 1 | Transmit port enable |
| rxEn | output | 1 | Receive port enable |
| pwrEn | output | 1 | Master power enable |

## Verification
Every result, including the first high phase of the tone, is due exactly one edge after the inputs that cause it. The bench drives inputs on the falling edge. For each driven cycle it pushes one expected item into a queue, and the monitor pops that item just after the following rising edge, so each comparison lands on the cycle in which the registers update. The expected tone waveform is built cycle by cycle from the half-period rules, which makes mid-half disables, low-half disables and restarts from idle all fall on exact cycles.

// File: rtl/lnb_supply_pkg.sv
package lnb_supply_pkg;
  // Strobes from the mode decoder to the tone datapath
  typedef struct packed {
    logic run;   // tone requested this cycle
    logic halt;  // power off: cut tone immediately
  } toneCmd_t;

  localparam int CODE_W = 2;
endpackage

// File: rtl/lnb_mode_decode.sv
module lnb_mode_decode
  import lnb_supply_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enBit,
  input  logic              modeSel,
  input  logic              vhiBit,
  input  logic              dropComp,
  input  logic              txSel,
  input  logic              selPin,
  output logic [CODE_W-1:0] outCode,
  output logic [CODE_W-1:0] boostCode,
  output logic              txEn,
  output logic              rxEn,
  output logic              pwrEn,
  output toneCmd_t          toneCmd
);
  logic outHi;
  logic boostHi;

  always_comb begin
    // In word mode the pin picks the level; in tone mode the bit does.
    outHi   = modeSel ? selPin : vhiBit;
    // In word mode the bit forces the boost rail high.
    boostHi = modeSel ? (selPin | vhiBit) : vhiBit;
    toneCmd.run  = enBit & ~modeSel & selPin;
    toneCmd.halt = ~enBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outCode   <= '0;
      boostCode <= '0;
      txEn      <= 1'b0;
      rxEn      <= 1'b0;
      pwrEn     <= 1'b0;
    end else if (!enBit) begin
      outCode   <= '0;
      boostCode <= '0;
      txEn      <= 1'b0;
      rxEn      <= 1'b0;
      pwrEn     <= 1'b0;
    end else begin
      outCode   <= {outHi, dropComp};
      boostCode <= {boostHi, dropComp};
      txEn      <= txSel;
      rxEn      <= ~txSel;
      pwrEn     <= 1'b1;
    end
  end
endmodule

// File: rtl/lnb_tone_div.sv
module lnb_tone_div
  import lnb_supply_pkg::*;
#(
  parameter int CLK_HZ  = 125_000_000,
  parameter int TONE_HZ = 22_000
) (
  input  logic     clk,
  input  logic     rstN,
  input  toneCmd_t toneCmd,
  output logic     toneOut
);
  localparam int HALF = CLK_HZ / (2 * TONE_HZ);
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic          running;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
      toneOut <= 1'b0;
    end else if (toneCmd.halt) begin
      running <= 1'b0;
      cnt     <= '0;
      toneOut <= 1'b0;
    end else if (!running) begin
      if (toneCmd.run) begin
        running <= 1'b1;
        cnt     <= '0;
        toneOut <= 1'b1;
      end
    end else if (!toneOut && !toneCmd.run) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (cnt == LAST) begin
      cnt     <= '0;
      toneOut <= ~toneOut;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lnb_supply_ctrl.sv
module lnb_supply_ctrl
  import lnb_supply_pkg::*;
#(
  parameter int CLK_HZ  = 125_000_000,
  parameter int TONE_HZ = 22_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enBit,
  input  logic       modeSel,
  input  logic       vhiBit,
  input  logic       dropComp,
  input  logic       txSel,
  input  logic       selPin,
  output logic [1:0] outCode,
  output logic [1:0] boostCode,
  output logic       toneOut,
  output logic       txEn,
  output logic       rxEn,
  output logic       pwrEn
);
  toneCmd_t toneCmd;

  lnb_mode_decode decode_i (
    .clk(clk), .rstN(rstN), .enBit(enBit), .modeSel(modeSel),
    .vhiBit(vhiBit), .dropComp(dropComp), .txSel(txSel), .selPin(selPin),
    .outCode(outCode), .boostCode(boostCode), .txEn(txEn), .rxEn(rxEn),
    .pwrEn(pwrEn), .toneCmd(toneCmd)
  );

  lnb_tone_div #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ)) tone_i (
    .clk(clk), .rstN(rstN), .toneCmd(toneCmd), .toneOut(toneOut)
  );
endmodule

// File: rtl/lnb_supply_ctrl_chk.sv
module lnb_supply_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enBit,
  input logic       modeSel,
  input logic       vhiBit,
  input logic       dropComp,
  input logic       txSel,
  input logic       selPin,
  input logic [1:0] outCode,
  input logic [1:0] boostCode,
  input logic       toneOut,
  input logic       txEn,
  input logic       rxEn,
  input logic       pwrEn
);
  a_r1_power_off: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> (!pwrEn && !txEn && !rxEn && !toneOut && outCode == 2'b00 && boostCode == 2'b00));

  a_r7_tx_port: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && txSel) |=> (txEn && !rxEn && pwrEn));

  a_r7_rx_port: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && !txSel) |=> (rxEn && !txEn && pwrEn));

  a_r3_drop_step: assert property (@(posedge clk) disable iff (!rstN)
    enBit |=> (outCode[0] == $past(dropComp) && boostCode[0] == $past(dropComp)));

  a_r6_boost_forced: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && modeSel && vhiBit) |=> (boostCode[1] && outCode[1] == $past(selPin)));

  a_r2_tone_mode_level: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && !modeSel) |=> (outCode[1] == $past(vhiBit) && boostCode == outCode));

  a_r10_no_spurious_tone: assert property (@(posedge clk) disable iff (!rstN)
    (!(enBit && !modeSel && selPin) && !toneOut) |=> !toneOut);
endmodule

bind lnb_supply_ctrl lnb_supply_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .enBit(enBit), .modeSel(modeSel), .vhiBit(vhiBit),
  .dropComp(dropComp), .txSel(txSel), .selPin(selPin), .outCode(outCode),
  .boostCode(boostCode), .toneOut(toneOut), .txEn(txEn), .rxEn(rxEn), .pwrEn(pwrEn)
);

// File: tb/lnb_supply_ctrl_tb_top.sv
`timescale 1ns/1ps
module lnb_supply_ctrl_tb_top;
  localparam int HALF = 125_000_000 / (2 * 22_000);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enBit = 0, modeSel = 0, vhiBit = 0, dropComp = 0, txSel = 0, selPin = 0;
  logic [1:0] outCode, boostCode;
  logic toneOut, txEn, rxEn, pwrEn;

  always #4 clk = ~clk;

  lnb_supply_ctrl dut_i (
    .clk(clk), .rstN(rstN), .enBit(enBit), .modeSel(modeSel), .vhiBit(vhiBit),
    .dropComp(dropComp), .txSel(txSel), .selPin(selPin), .outCode(outCode),
    .boostCode(boostCode), .toneOut(toneOut), .txEn(txEn), .rxEn(rxEn), .pwrEn(pwrEn)
  );

  typedef struct {
    logic [1:0] oc;
    logic [1:0] bc;
    logic tone, tx, rx, pwr;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference tone model, built from the half-period rules
  bit mRun = 0;
  bit mTone = 0;
  int mCnt = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic push(input string tag);
    exp_t e;
    bit req;
    req = enBit && !modeSel && selPin;
    if (!enBit) begin
      e.oc = 0; e.bc = 0; e.tx = 0; e.rx = 0; e.pwr = 0;
    end else begin
      e.oc  = {modeSel ? selPin : vhiBit, dropComp};
      e.bc  = {modeSel ? (selPin | vhiBit) : vhiBit, dropComp};
      e.tx  = txSel;
      e.rx  = !txSel;
      e.pwr = 1;
    end
    if (!enBit) begin
      mRun = 0; mCnt = 0; mTone = 0;
    end else if (!mRun) begin
      if (req) begin mRun = 1; mCnt = 0; mTone = 1; end
    end else if (!mTone && !req) begin
      mRun = 0; mCnt = 0;
    end else if (mCnt == HALF - 1) begin
      mCnt = 0; mTone = !mTone;
    end else begin
      mCnt++;
    end
    e.tone = mTone;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive(input logic en, input logic om, input logic vom, input logic llc,
                       input logic ttx, input logic pin, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      enBit = en; modeSel = om; vhiBit = vom; dropComp = llc; txSel = ttx; selPin = pin;
      push(tag);
    end
  endtask

  // Monitor: each expected item is due one edge after it was driven
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " outCode"}, {6'd0, outCode}, {6'd0, e.oc});
        chk({e.tag, " boostCode"}, {6'd0, boostCode}, {6'd0, e.bc});
        chk({e.tag, " ports"}, {5'd0, pwrEn, txEn, rxEn}, {5'd0, e.pwr, e.tx, e.rx});
        chk({e.tag, " toneOut"}, {7'd0, toneOut}, {7'd0, e.tone});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset outputs", {outCode, boostCode, toneOut, txEn, rxEn, pwrEn}, 8'd0);
    rstN = 1'b1;
    // R1: disabled, other bits set, tone request ignored
    drive(0, 0, 1, 1, 1, 1, 4, "R1 disabled");
    // R2/R7: tone mode, low level, rx port, pin low
    drive(1, 0, 0, 0, 0, 0, 3, "R2 low level rx R7");
    drive(1, 0, 1, 0, 0, 0, 3, "R2 high level");
    drive(1, 0, 1, 1, 1, 0, 3, "R3 high plus step tx R7");
    drive(1, 0, 0, 1, 1, 0, 3, "R3 low plus step R4");
    // R5: word mode, pin selects both levels; R10 no tone
    drive(1, 1, 0, 0, 0, 0, 3, "R5 pin low R10");
    drive(1, 1, 0, 0, 0, 1, 3, "R5 pin high R10");
    drive(1, 1, 0, 1, 0, 1, 3, "R5 pin high step R4");
    // R6: boost forced high
    drive(1, 1, 1, 0, 1, 0, 3, "R6 pin low boost forced");
    drive(1, 1, 1, 1, 1, 0, 3, "R6 pin low step");
    drive(1, 1, 1, 1, 1, 1, 3, "R6 pin high step");
    // R8: tone run for several periods
    drive(1, 0, 0, 0, 1, 1, 3 * HALF + 10, "R8 tone running");
    // R9: now in low half; drop pin -> idle low
    drive(1, 0, 0, 0, 1, 0, 20, "R9 drop in low half");
    // R9: restart at phase zero, drop mid-high half
    drive(1, 0, 0, 0, 1, 1, HALF / 2, "R9 restart");
    drive(1, 0, 0, 0, 1, 0, HALF, "R9 finish high half");
    // R1: enable drop cuts tone mid-half
    drive(1, 0, 0, 0, 1, 1, HALF / 3, "R8 second start");
    drive(0, 0, 0, 0, 1, 1, 5, "R1 cut tone");
    drive(1, 0, 1, 1, 0, 1, HALF + 20, "R8 restart after power");
    drive(1, 1, 1, 1, 0, 1, 10, "R10 mode switch");
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule